// File: doc/BRIEF.md
# Release List Expander

This block turns one release-list command into a stream of per-buffer transmit completion descriptors. A command carries a list of buffer records (each a 64-bit buffer address, a 20-bit cookie, a 19-bit timestamp and a 3-bit notify code) together with fields shared by the whole list: originator code, removal reason, owning-manager ID, 24-bit status number, 7-bit try count and the RSSI of the acknowledgement. The block captures the whole command in one cycle and then emits one 256-bit descriptor (eight 32-bit words, word k in bits 32k+31:32k) per record, in list order, on a valid/ready stream.

While it emits descriptors the block fills in the first and last markers, the owner-details bit and the RSSI rule. Fields that belong to other producers (rate statistics, peer and TID, loop count, error bits) are emitted as zero. The maximum list length is a parameter, and a command is accepted only when the previous list has fully drained.

Top module: `rel_list_expander`

## Requirements
- R1: An accepted command with length N (1 to MAX_ITEMS) produces exactly N descriptors, one per record, in list order (record 0 first); after the last handshake out_valid is 0 and cmd_ready is 1.
- R2: The first descriptor of a list has word 4 bit 8 set, the final descriptor has word 4 bit 9 set, and all others have both clear; a one-record list sets both bits on its single descriptor.
- R3: Word 3 bit 31 is 1 when the command's owning-manager ID differs from the parameter LOCAL_MGR_ID (default 0), and 0 when it equals it.
- R4: Per-record fields: address bits 31:0 in word 0 and 63:32 in word 1; cookie bits 11:0 in word 2 bits 29:18 and cookie bits 19:12 in word 7 bits 27:20; timestamp in word 4 bits 31:13; notify code in word 4 bits 12:10.
- R5: Word 4 bits 7:0 carry the command RSSI only when the originator code is 0 and the reason code is 0 (acknowledged); for any other reason they are 0x00.
- R6: Originator code goes to word 2 bits 2:0, owning-manager ID to word 2 bits 12:9, reason code to word 2 bits 16:13; status number goes to word 3 bits 23:0 and try count to word 3 bits 30:24 when the originator code is 0 (queue manager), and both are zero for any other originator (3 = firmware, 6 = software).
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_desc does not change.
- R8: cmd_ready is 1 only when no list is being emitted; a command offered while a list is in flight is ignored and does not alter the descriptors of that list.
- R9: A command with length 0 produces no descriptor and leaves the block idle; a length above MAX_ITEMS is treated as MAX_ITEMS.
- R10: After reset out_valid is 0 and cmd_ready is 1.
- R11: Word 2 bit 30 (cookie converted) is 1; all other bits not named in R2 to R6 are 0, including words 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on this cycle if valid |
| cmd_count | input | CNT_W | Number of records in the list |
| cmd_addr | input | MAX_ITEMS*64 | Buffer addresses, record i at bits 64i+63:64i |
| cmd_cookie | input | MAX_ITEMS*20 | Cookies, record i at bits 20i+19:20i |
| cmd_stamp | input | MAX_ITEMS*19 | Timestamps, record i at bits 19i+18:19i |
| cmd_note | input | MAX_ITEMS*3 | Notify codes, record i at bits 3i+2:3i |
| cmd_src | input | 3 | Originator code |
| cmd_why | input | 4 | Removal reason code |
| cmd_mgr | input | 4 | Owning-manager ID |
| cmd_seq | input | 24 | Status number |
| cmd_tries | input | 7 | Try count |
| cmd_rssi | input | 8 | Acknowledgement RSSI |
| out_valid | output | 1 | Descriptor available |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_desc | output | 256 | Eight-word completion descriptor |

## Verification
The checker watches on every cycle that a stalled descriptor is held steady, that no command is taken while a list is in flight, that a removal-reason descriptor never carries a nonzero RSSI, that a non-queue-manager descriptor carries no status or try count, that the owner-details bit matches the manager field, and that an accepted list begins with the first marker and stops after the last marker. Only the bench scenarios show that each record arrives with its own address, cookie, timestamp and notify code, in order and with the right count, including one-record lists, clamped oversize lengths, zero-length commands and commands offered during a stall.

// File: rtl/rlx_pkg.sv
// Shared types and field widths for the release list expander.
// Assumes the descriptor is eight 32-bit words, flattened low word first.
package rlx_pkg;

    localparam int ADDR_W   = 64;
    localparam int COOKIE_W = 20;
    localparam int STAMP_W  = 19;
    localparam int NOTE_W   = 3;
    localparam int SRC_W    = 3;
    localparam int WHY_W    = 4;
    localparam int MGR_W    = 4;
    localparam int SEQ_W    = 24;
    localparam int TRIES_W  = 7;
    localparam int RSSI_W   = 8;
    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 8;
    localparam int DESC_W   = WORD_W * N_WORDS;

    localparam logic [SRC_W-1:0] SRC_QUEUE_MGR = 3'd0;
    localparam logic [WHY_W-1:0] WHY_ACKED     = 4'd0;

    // One buffer record of a release list.
    typedef struct packed {
        logic [ADDR_W-1:0]   addr;
        logic [COOKIE_W-1:0] cookie;
        logic [STAMP_W-1:0]  stamp;
        logic [NOTE_W-1:0]   note;
    } item_t;

    // Fields common to every record of one command.
    typedef struct packed {
        logic [SRC_W-1:0]   src;
        logic [WHY_W-1:0]   why;
        logic [MGR_W-1:0]   mgr;
        logic [SEQ_W-1:0]   seq;
        logic [TRIES_W-1:0] tries;
        logic [RSSI_W-1:0]  rssi;
    } shared_t;

    localparam int ITEM_W = $bits(item_t);

endpackage

// File: rtl/rlx_list_store.sv
// Holds the records and shared fields of the command being expanded.
// Assumes load is only raised when no list is in flight; sel is the
// index of the record currently presented on the output.
module rlx_list_store
    import rlx_pkg::*;
#(
    parameter int MAX_ITEMS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [MAX_ITEMS*ITEM_W-1:0]   items_flat,
    input  shared_t                       shared_in,
    input  logic [IDX_W-1:0]              sel,
    output item_t                         item_sel,
    output shared_t                       shared_q
);

    item_t slot_q [MAX_ITEMS];

    // One register per list slot, written together when a command is taken.
    for (genvar i = 0; i < MAX_ITEMS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (load) begin
                slot_q[i] <= item_t'(items_flat[i*ITEM_W +: ITEM_W]);
            end
        end
    end

    // Shared fields captured alongside the records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shared_q <= '0;
        end else if (load) begin
            shared_q <= shared_in;
        end
    end

    // Select the record being emitted; out-of-range index yields zero.
    always_comb begin
        if (int'(sel) < MAX_ITEMS) begin
            item_sel = slot_q[sel];
        end else begin
            item_sel = '0;
        end
    end

endmodule

// File: rtl/rlx_walker.sv
// Control for list iteration: takes a command when idle, steps through
// its records one handshake at a time and marks first and last.
// Assumes cmd_count may exceed MAX_ITEMS; such lengths are clamped.
module rlx_walker #(
    parameter int MAX_ITEMS = 8,
    parameter int CNT_W     = 4,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             out_ready,
    output logic             cmd_ready,
    output logic             load,
    output logic             out_valid,
    output logic [IDX_W-1:0] idx,
    output logic             is_first,
    output logic             is_last
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ITEMS);

    logic             busy_q;
    logic [CNT_W-1:0] len_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] eff_len;
    logic [CNT_W-1:0] idx_ext;

    // Clamp the requested length to the storage depth.
    always_comb begin
        eff_len = (cmd_count > LIMIT) ? LIMIT : cmd_count;
    end

    // Take a non-empty command when idle; empty commands are dropped.
    always_comb begin
        cmd_ready = !busy_q;
        load      = !busy_q && cmd_valid && (eff_len != '0);
    end

    // Position markers for the record currently presented.
    always_comb begin
        idx_ext  = CNT_W'(idx_q);
        is_first = (idx_q == '0);
        is_last  = ((idx_ext + CNT_W'(1)) == len_q);
    end

    // Iteration state: busy flag, list length and current index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            len_q  <= '0;
            idx_q  <= '0;
        end else if (!busy_q) begin
            if (load) begin
                busy_q <= 1'b1;
                len_q  <= eff_len;
                idx_q  <= '0;
            end
        end else if (out_ready) begin
            if (is_last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign out_valid = busy_q;
    assign idx       = idx_q;

endmodule

// File: rtl/rlx_desc_pack.sv
// Builds the eight-word completion descriptor for one record.
// Purely combinational; assumes its inputs are register outputs so the
// descriptor is stable whenever they are.
module rlx_desc_pack
    import rlx_pkg::*;
#(
    parameter logic [3:0] LOCAL_MGR_ID = 4'd0
) (
    input  item_t              item,
    input  shared_t            shared,
    input  logic               is_first,
    input  logic               is_last,
    output logic [DESC_W-1:0]  desc
);

    logic [WORD_W-1:0] w [N_WORDS];
    logic              from_queue;
    logic              was_acked;

    // Qualifiers that gate the conditional fields.
    always_comb begin
        from_queue = (shared.src == SRC_QUEUE_MGR);
        was_acked  = from_queue && (shared.why == WHY_ACKED);
    end

    // Field placement, one word at a time.
    always_comb begin
        for (int k = 0; k < N_WORDS; k++) begin
            w[k] = '0;
        end
        w[0]        = item.addr[31:0];
        w[1]        = item.addr[63:32];
        w[2][2:0]   = shared.src;
        w[2][12:9]  = shared.mgr;
        w[2][16:13] = shared.why;
        w[2][29:18] = item.cookie[11:0];
        w[2][30]    = 1'b1;
        if (from_queue) begin
            w[3][23:0]  = shared.seq;
            w[3][30:24] = shared.tries;
        end
        w[3][31]    = (shared.mgr != LOCAL_MGR_ID);
        if (was_acked) begin
            w[4][7:0] = shared.rssi;
        end
        w[4][8]     = is_first;
        w[4][9]     = is_last;
        w[4][12:10] = item.note;
        w[4][31:13] = item.stamp;
        w[7][27:20] = item.cookie[19:12];
    end

    // Flatten the words, word 0 in the low bits.
    for (genvar k = 0; k < N_WORDS; k++) begin : g_flat
        assign desc[k*WORD_W +: WORD_W] = w[k];
    end

endmodule

// File: rtl/rel_list_expander.sv
// Top of the release list expander. Captures a list command, then emits
// one completion descriptor per record on a valid/ready stream.
// Assumes the consumer may stall at any time; a new command is taken
// only once the previous list has fully drained.
module rel_list_expander
    import rlx_pkg::*;
#(
    parameter int         MAX_ITEMS    = 8,
    parameter logic [3:0] LOCAL_MGR_ID = 4'd0,
    localparam int        CNT_W        = $clog2(MAX_ITEMS + 1),
    localparam int        IDX_W        = (MAX_ITEMS > 1) ? $clog2(MAX_ITEMS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    output logic                          cmd_ready,
    input  logic [CNT_W-1:0]              cmd_count,
    input  logic [MAX_ITEMS*64-1:0]       cmd_addr,
    input  logic [MAX_ITEMS*20-1:0]       cmd_cookie,
    input  logic [MAX_ITEMS*19-1:0]       cmd_stamp,
    input  logic [MAX_ITEMS*3-1:0]        cmd_note,
    input  logic [2:0]                    cmd_src,
    input  logic [3:0]                    cmd_why,
    input  logic [3:0]                    cmd_mgr,
    input  logic [23:0]                   cmd_seq,
    input  logic [6:0]                    cmd_tries,
    input  logic [7:0]                    cmd_rssi,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [255:0]                  out_desc
);

    logic [MAX_ITEMS*ITEM_W-1:0] items_flat;
    shared_t                     shared_in;
    shared_t                     shared_q;
    item_t                       item_sel;
    logic                        load;
    logic [IDX_W-1:0]            idx;
    logic                        is_first;
    logic                        is_last;

    // Gather each record's fields from the per-field port vectors.
    for (genvar i = 0; i < MAX_ITEMS; i++) begin : g_gather
        assign items_flat[i*ITEM_W +: ITEM_W] = {cmd_addr[i*ADDR_W +: ADDR_W],
                                                 cmd_cookie[i*COOKIE_W +: COOKIE_W],
                                                 cmd_stamp[i*STAMP_W +: STAMP_W],
                                                 cmd_note[i*NOTE_W +: NOTE_W]};
    end

    assign shared_in = '{src: cmd_src, why: cmd_why, mgr: cmd_mgr,
                         seq: cmd_seq, tries: cmd_tries, rssi: cmd_rssi};

    rlx_walker #(
        .MAX_ITEMS (MAX_ITEMS),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_count (cmd_count),
        .out_ready (out_ready),
        .cmd_ready (cmd_ready),
        .load      (load),
        .out_valid (out_valid),
        .idx       (idx),
        .is_first  (is_first),
        .is_last   (is_last)
    );

    rlx_list_store #(
        .MAX_ITEMS (MAX_ITEMS),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .items_flat (items_flat),
        .shared_in  (shared_in),
        .sel        (idx),
        .item_sel   (item_sel),
        .shared_q   (shared_q)
    );

    rlx_desc_pack #(
        .LOCAL_MGR_ID (LOCAL_MGR_ID)
    ) u_pack (
        .item     (item_sel),
        .shared   (shared_q),
        .is_first (is_first),
        .is_last  (is_last),
        .desc     (out_desc)
    );

endmodule

// File: rtl/rlx_checker.sv
// Protocol and field checks for rel_list_expander, attached by bind.
module rlx_checker #(
    parameter int         MAX_ITEMS    = 8,
    parameter logic [3:0] LOCAL_MGR_ID = 4'd0,
    localparam int        CNT_W        = $clog2(MAX_ITEMS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CNT_W-1:0] cmd_count,
    input logic             out_valid,
    input logic             out_ready,
    input logic [255:0]     out_desc
);

    // R7: a stalled descriptor stays presented and unchanged.
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_desc));

    // R8: no command is taken while a list is in flight.
    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_ready);

    // R5: a removal reason never carries an RSSI value.
    a_r5_rssi_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_desc[80:77] != 4'd0) |-> out_desc[135:128] == 8'h00);

    // R6: status and try count only for the queue-manager originator.
    a_r6_status_gated: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_desc[66:64] != 3'd0) |-> out_desc[126:96] == 31'd0);

    // R3: owner-details bit tracks the manager field.
    a_r3_details_bit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_desc[127] == (out_desc[76:73] != LOCAL_MGR_ID));

    // R2: an accepted non-empty list begins with the first marker.
    a_r2_first_marker: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_count != '0) |=> out_valid && out_desc[136]);

    // R1: the stream stops after the last-marked descriptor is taken.
    a_r1_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_desc[137] |=> !out_valid);

    // R9: an empty command starts nothing.
    a_r9_empty_list: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_count == '0) |=> !out_valid);

endmodule

bind rel_list_expander rlx_checker #(
    .MAX_ITEMS    (MAX_ITEMS),
    .LOCAL_MGR_ID (LOCAL_MGR_ID)
) u_rlx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_count (cmd_count),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_desc  (out_desc)
);

// File: tb/rel_list_expander_bench.sv
// Directed bench for rel_list_expander: one task per scenario.
module rel_list_expander_bench;

    localparam int         MAX   = 8;
    localparam int         CW    = $clog2(MAX + 1);
    localparam logic [3:0] LOCAL = 4'd0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [CW-1:0]    cmd_count = '0;
    logic [MAX*64-1:0] cmd_addr = '0;
    logic [MAX*20-1:0] cmd_cookie = '0;
    logic [MAX*19-1:0] cmd_stamp = '0;
    logic [MAX*3-1:0]  cmd_note = '0;
    logic [2:0]       cmd_src = '0;
    logic [3:0]       cmd_why = '0;
    logic [3:0]       cmd_mgr = '0;
    logic [23:0]      cmd_seq = '0;
    logic [6:0]       cmd_tries = '0;
    logic [7:0]       cmd_rssi = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [255:0]     out_desc;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Expected-value copies of the command being run.
    logic [63:0] e_addr   [MAX];
    logic [19:0] e_cookie [MAX];
    logic [18:0] e_stamp  [MAX];
    logic [2:0]  e_note   [MAX];
    logic [2:0]  e_src;
    logic [3:0]  e_why, e_mgr;
    logic [23:0] e_seq;
    logic [6:0]  e_tries;
    logic [7:0]  e_rssi;

    always #2.5 clk = ~clk;

    rel_list_expander #(.MAX_ITEMS(MAX), .LOCAL_MGR_ID(LOCAL)) u_rel_list_expander (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_count(cmd_count), .cmd_addr(cmd_addr), .cmd_cookie(cmd_cookie),
        .cmd_stamp(cmd_stamp), .cmd_note(cmd_note), .cmd_src(cmd_src),
        .cmd_why(cmd_why), .cmd_mgr(cmd_mgr), .cmd_seq(cmd_seq),
        .cmd_tries(cmd_tries), .cmd_rssi(cmd_rssi), .out_valid(out_valid),
        .out_ready(out_ready), .out_desc(out_desc)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected descriptor for record k, built from the requirement text.
    function automatic logic [255:0] exp_desc(input int k, input logic f, input logic l);
        logic [255:0] d;
        d = '0;
        d[63:0]    = e_addr[k];                      // R4
        d[66:64]   = e_src;                          // R6
        d[76:73]   = e_mgr;
        d[80:77]   = e_why;
        d[93:82]   = e_cookie[k][11:0];              // R4
        d[94]      = 1'b1;                           // R11
        if (e_src == 3'd0) begin
            d[119:96]  = e_seq;
            d[126:120] = e_tries;
        end
        d[127]     = (e_mgr != LOCAL);               // R3
        if (e_src == 3'd0 && e_why == 4'd0) d[135:128] = e_rssi;  // R5
        d[136]     = f;                              // R2
        d[137]     = l;
        d[140:138] = e_note[k];
        d[159:141] = e_stamp[k];
        d[251:244] = e_cookie[k][19:12];
        return d;
    endfunction

    // Fill record fields and shared fields on the ports and in the copies.
    task automatic setup(input int base, input logic [2:0] src, input logic [3:0] why,
                         input logic [3:0] mgr);
        for (int k = 0; k < MAX; k++) begin
            e_addr[k]   = {32'hC0DE_0000 | 32'(base << 8) | 32'(k), 32'h8000_0000 + 32'(base * 64 + k * 16)};
            e_cookie[k] = 20'h5A000 + 20'(base * 16 + k);
            e_stamp[k]  = 19'h12340 + 19'(base * 3 + k * 7);
            e_note[k]   = 3'(k + base);
            cmd_addr[k*64 +: 64]   = e_addr[k];
            cmd_cookie[k*20 +: 20] = e_cookie[k];
            cmd_stamp[k*19 +: 19]  = e_stamp[k];
            cmd_note[k*3 +: 3]     = e_note[k];
        end
        e_src = src; e_why = why; e_mgr = mgr;
        e_seq = 24'hA5_0000 + 24'(base); e_tries = 7'(base + 5); e_rssi = 8'hB0 + 8'(base);
        cmd_src = e_src; cmd_why = e_why; cmd_mgr = e_mgr;
        cmd_seq = e_seq; cmd_tries = e_tries; cmd_rssi = e_rssi;
    endtask

    // Issue one command and drain n_exp descriptors, optionally stalling
    // and offering a second command during the stall.
    task automatic run_list(input int n_req, input int n_exp, input bit stall, input bit intrude);
        logic [255:0] got;
        logic [255:0] want;
        cmd_count = CW'(n_req);
        cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < n_exp; k++) begin
            want = exp_desc(k, k == 0, k == n_exp - 1);
            check("R1 valid per record", 256'(out_valid), 256'(1));
            got = out_desc;
            check("R4/R11 descriptor", got, want);
            check("R2 first/last", 256'(got[137:136]), 256'(want[137:136]));
            check("R3 details bit", 256'(got[127]), 256'(want[127]));
            check("R5 rssi", 256'(got[135:128]), 256'(want[135:128]));
            check("R6 status/tries", 256'(got[126:96]), 256'(want[126:96]));
            if (stall) begin
                for (int s = 0; s < 2; s++) begin
                    if (intrude) begin
                        cmd_valid = 1'b1;
                        cmd_count = CW'(1);
                        cmd_src   = 3'd6;
                        cmd_addr[63:0] = 64'hDEAD_BEEF_DEAD_BEEF;
                    end
                    @(posedge clk); @(negedge clk);
                    check("R7 held on stall", out_desc, got);
                    check("R8 busy not ready", 256'(cmd_ready), 256'(0));
                end
                cmd_valid = 1'b0;
            end
            out_ready = 1'b1;
            @(posedge clk); @(negedge clk);
            out_ready = 1'b0;
        end
        check("R1 idle after list", 256'(out_valid), 256'(0));
        check("R1 ready after list", 256'(cmd_ready), 256'(1));
    endtask

    task automatic t_reset;
        check("R10 out_valid after reset", 256'(out_valid), 256'(0));
        check("R10 cmd_ready after reset", 256'(cmd_ready), 256'(1));
    endtask

    task automatic t_acked_remote;      // R1 R3 R5: three records, acked, remote owner
        setup(1, 3'd0, 4'd0, 4'd3);
        run_list(3, 3, 0, 0);
    endtask

    task automatic t_single;            // R2: one record sets both markers
        setup(2, 3'd0, 4'd0, 4'd2);
        run_list(1, 1, 0, 0);
    endtask

    task automatic t_full_local_stall;  // R7 R8 R3 R5: full list, local owner, removal
        setup(3, 3'd0, 4'd1, LOCAL);
        run_list(MAX, MAX, 1, 1);
        cmd_src = e_src;
    endtask

    task automatic t_firmware;          // R6: firmware originator zeroes status
        setup(4, 3'd3, 4'd0, 4'd7);
        run_list(2, 2, 0, 0);
        setup(5, 3'd6, 4'd14, 4'd1);    // software originator, top legal reason
        run_list(2, 2, 1, 0);
    endtask

    task automatic t_empty;             // R9: empty list emits nothing
        setup(6, 3'd0, 4'd0, 4'd1);
        run_list(0, 0, 0, 0);
        for (int s = 0; s < 3; s++) begin
            @(posedge clk); @(negedge clk);
            check("R9 empty list idle", 256'(out_valid), 256'(0));
        end
    endtask

    task automatic t_oversize;          // R9: length above MAX clamps
        setup(7, 3'd0, 4'd0, 4'd5);
        run_list(12, MAX, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_acked_remote();
        t_single();
        t_full_local_stall();
        t_firmware();
        t_empty();
        t_oversize();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule